// File: doc/BRIEF.md
# Flash Command Interpreter with Erase Suspend

This block sits between a host bus and the erase/program sequencer of an embedded flash controller. Each bus write presents an 8-bit command byte and an address, framed by two active-low strobes: chip enable and write enable. The write ends when the first of the two strobes returns high. At that point the block decodes the byte. From the decoded commands it tracks which source the read path should show (the array, the status byte or the identifier). It also issues single-cycle start, suspend and resume requests to the sequencer.

An erase takes two writes: a setup byte, then a confirm byte. The target block number is taken from the address of the confirm write. While the sequencer reports that an erase is suspended, only a small set of commands takes effect. An active-low power-down input returns the block to its default state. After that input is released, writes stay blocked for a set number of clocks while the block recovers.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write is accepted when the first of `ceN` or `weN` rises after both have been low. The byte and address used are those present in the last clock in which both strobes were low. Changes on the bus after that are ignored.
- R2: Command FFh selects the array (`readSel` = 0), 70h selects status (`readSel` = 1), and 90h selects the identifier (`readSel` = 2). Each takes effect in the clock after the write ends.
- R3: Write 20h and then D0h while the sequencer is idle. The block gives a one-cycle `eraseStart` pulse, sets `readSel` to 1, and loads `blockAddr` from the top BLK_W address bits of the D0h write.
- R4: If 20h is followed by any byte other than D0h, the block sets `errFlag`, sets `readSel` to 1, and gives no `eraseStart`.
- R5: B0h while `seqBusy` is high and `seqSuspended` is low gives a one-cycle `suspendReq` pulse and sets `readSel` to 1. B0h while the sequencer is idle has no effect.
- R6: While `seqSuspended` is high, only FFh, 70h and D0h take effect. Every other byte leaves `readSel` unchanged and produces no pulse.
- R7: D0h while `seqSuspended` is high gives a one-cycle `resumeReq` pulse and sets `readSel` to 1.
- R8: While `pwrDownN` is low, all of the following hold:
  - writes are ignored;
  - `seqRstN` is low;
  - `errFlag` clears;
  - any pending setup is dropped;
  - `readSel` returns to 0, which is also its value after `rstN`.
- R9: After `rstN` or `pwrDownN` is released, a write whose end is seen within RECOV_CYC clocks is ignored.
- R10: While `seqBusy` is high and `seqSuspended` is low, 20h and D0h have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous system reset, active low |
| pwrDownN | input | 1 | Reset/power-down request, active low |
| ceN | input | 1 | Chip enable strobe, active low |
| weN | input | 1 | Write enable strobe, active low |
| busData | input | 8 | Command byte |
| busAddr | input | ADDR_W | Write address |
| seqBusy | input | 1 | Sequencer is running an erase |
| seqSuspended | input | 1 | Sequencer has reached the suspended state |
| readSel | output | 2 | Read path source: 0 array, 1 status, 2 identifier |
| blockAddr | output | BLK_W | Block number captured on erase confirm |
| eraseStart | output | 1 | One-cycle erase start request |
| suspendReq | output | 1 | One-cycle suspend request |
| resumeReq | output | 1 | One-cycle resume request |
| errFlag | output | 1 | Command-sequence error |
| seqRstN | output | 1 | Sequencer reset, active low |

## Verification
The bench sweeps every byte value in two places: as the byte after an erase setup, and as a command while the erase is suspended. A decoder that let a wrong confirm byte start an erase, or that let the identifier or setup command through during suspend, would change `readSel` or emit a stray pulse. Both strobe orders are exercised, with the data changed after the first strobe has risen. A design that latched on the second edge would therefore pick up the wrong byte. Writes are also placed inside the recovery window and during power-down, where a block that forgot the block-out would change mode.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    SEL_ARRAY  = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_IDENT  = 2'd2
  } readSel_e;

  // Strobes from control to datapath, valid in the commit cycle
  typedef struct packed {
    logic latchBlk;
    logic setErr;
  } ctlStrobe_t;

  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_READ_IDENT  = 8'h90;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

endpackage

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BLK_W     = 3,
  parameter int RECOV_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrDownN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [7:0]        busData,
  input  logic [ADDR_W-1:0] busAddr,
  input  ctlStrobe_t        ctl,
  output logic              commit,
  output logic [7:0]        cmdByte,
  output logic [BLK_W-1:0]  blockAddr,
  output logic              errFlag
);

  localparam int CNT_W = $clog2(RECOV_CYC + 2);
  localparam logic [CNT_W-1:0] RECOV_LOAD = CNT_W'(RECOV_CYC);

  logic              wrActive;
  logic              prevActive;
  logic [ADDR_W-1:0] capAddr;
  logic [CNT_W-1:0]  recovCnt;

  assign wrActive = !ceN && !weN;
  // end of write: first strobe has gone high
  assign commit   = prevActive && !wrActive && (recovCnt == '0) && pwrDownN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActive <= 1'b0;
      cmdByte    <= '0;
      capAddr    <= '0;
      recovCnt   <= RECOV_LOAD;
      blockAddr  <= '0;
      errFlag    <= 1'b0;
    end else if (!pwrDownN) begin
      prevActive <= 1'b0;
      recovCnt   <= RECOV_LOAD;
      errFlag    <= 1'b0;
    end else begin
      prevActive <= wrActive;
      if (wrActive) begin
        cmdByte <= busData;
        capAddr <= busAddr;
      end
      if (recovCnt != '0) recovCnt <= recovCnt - 1'b1;
      if (ctl.setErr)   errFlag   <= 1'b1;
      if (ctl.latchBlk) blockAddr <= capAddr[ADDR_W-1 -: BLK_W];
    end
  end

endmodule

// File: rtl/flash_cmd_ctl.sv
module flash_cmd_ctl
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDownN,
  input  logic       commit,
  input  logic [7:0] cmdByte,
  input  logic       seqBusy,
  input  logic       seqSuspended,
  output logic [1:0] readSel,
  output logic       eraseStart,
  output logic       suspendReq,
  output logic       resumeReq,
  output ctlStrobe_t ctl
);

  readSel_e selQ, selD;
  logic     setupPend, setupPendD;
  logic     startD, suspD, resD;

  always_comb begin
    selD       = selQ;
    setupPendD = setupPend;
    startD     = 1'b0;
    suspD      = 1'b0;
    resD       = 1'b0;
    ctl        = '0;
    if (commit) begin
      if (setupPend) begin
        setupPendD = 1'b0;
        selD       = SEL_STATUS;
        if (cmdByte == CMD_CONFIRM) begin
          startD       = 1'b1;
          ctl.latchBlk = 1'b1;
        end else begin
          ctl.setErr = 1'b1;
        end
      end else if (seqSuspended) begin
        unique case (cmdByte)
          CMD_READ_ARRAY:  selD = SEL_ARRAY;
          CMD_READ_STATUS: selD = SEL_STATUS;
          CMD_CONFIRM: begin
            resD = 1'b1;
            selD = SEL_STATUS;
          end
          default: ;
        endcase
      end else if (seqBusy) begin
        unique case (cmdByte)
          CMD_READ_ARRAY:  selD = SEL_ARRAY;
          CMD_READ_STATUS: selD = SEL_STATUS;
          CMD_READ_IDENT:  selD = SEL_IDENT;
          CMD_SUSPEND: begin
            suspD = 1'b1;
            selD  = SEL_STATUS;
          end
          default: ;
        endcase
      end else begin
        unique case (cmdByte)
          CMD_READ_ARRAY:  selD = SEL_ARRAY;
          CMD_READ_STATUS: selD = SEL_STATUS;
          CMD_READ_IDENT:  selD = SEL_IDENT;
          CMD_ERASE_SETUP: begin
            setupPendD = 1'b1;
            selD       = SEL_STATUS;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ       <= SEL_ARRAY;
      setupPend  <= 1'b0;
      eraseStart <= 1'b0;
      suspendReq <= 1'b0;
      resumeReq  <= 1'b0;
    end else if (!pwrDownN) begin
      selQ       <= SEL_ARRAY;
      setupPend  <= 1'b0;
      eraseStart <= 1'b0;
      suspendReq <= 1'b0;
      resumeReq  <= 1'b0;
    end else begin
      selQ       <= selD;
      setupPend  <= setupPendD;
      eraseStart <= startD;
      suspendReq <= suspD;
      resumeReq  <= resD;
    end
  end

  assign readSel = selQ;

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BLK_W     = 3,
  parameter int RECOV_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrDownN,
  input  logic              ceN,
  input  logic              weN,
  input  logic [7:0]        busData,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              seqBusy,
  input  logic              seqSuspended,
  output logic [1:0]        readSel,
  output logic [BLK_W-1:0]  blockAddr,
  output logic              eraseStart,
  output logic              suspendReq,
  output logic              resumeReq,
  output logic              errFlag,
  output logic              seqRstN
);

  ctlStrobe_t ctl;
  logic       commit;
  logic [7:0] cmdByte;

  flash_cmd_dp #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .RECOV_CYC(RECOV_CYC)
  ) uDp (
    .clk(clk), .rstN(rstN), .pwrDownN(pwrDownN),
    .ceN(ceN), .weN(weN), .busData(busData), .busAddr(busAddr),
    .ctl(ctl), .commit(commit), .cmdByte(cmdByte),
    .blockAddr(blockAddr), .errFlag(errFlag)
  );

  flash_cmd_ctl uCtl (
    .clk(clk), .rstN(rstN), .pwrDownN(pwrDownN),
    .commit(commit), .cmdByte(cmdByte),
    .seqBusy(seqBusy), .seqSuspended(seqSuspended),
    .readSel(readSel), .eraseStart(eraseStart),
    .suspendReq(suspendReq), .resumeReq(resumeReq), .ctl(ctl)
  );

  assign seqRstN = rstN && pwrDownN;

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic       clk,
  input logic       rstN,
  input logic       pwrDownN,
  input logic       seqBusy,
  input logic       seqSuspended,
  input logic [1:0] readSel,
  input logic       eraseStart,
  input logic       suspendReq,
  input logic       resumeReq,
  input logic       errFlag
);

  p_pd_array_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |=> (readSel == 2'd0) && !errFlag);

  p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pwrDownN |=> !eraseStart && !suspendReq && !resumeReq);

  p_one_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({eraseStart, suspendReq, resumeReq}));

  p_start_status_r3: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |-> readSel == 2'd1);

  p_susp_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    suspendReq |-> $past(seqBusy) && !$past(seqSuspended));

  p_resume_susp_r7: assert property (@(posedge clk) disable iff (!rstN)
    resumeReq |-> $past(seqSuspended) && readSel == 2'd1);

  p_no_start_susp_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(seqSuspended) |-> !eraseStart && !suspendReq);

endmodule

bind flash_cmd_ctrl flash_cmd_chk uChk (
  .clk(clk), .rstN(rstN), .pwrDownN(pwrDownN),
  .seqBusy(seqBusy), .seqSuspended(seqSuspended),
  .readSel(readSel), .eraseStart(eraseStart),
  .suspendReq(suspendReq), .resumeReq(resumeReq), .errFlag(errFlag)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int BLK_W = 3;
  localparam int RECOV_CYC = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pwrDownN = 1'b1;
  logic ceN = 1'b1;
  logic weN = 1'b1;
  logic [7:0] busData = '0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic seqBusy = 1'b0;
  logic seqSuspended = 1'b0;
  logic [1:0] readSel;
  logic [BLK_W-1:0] blockAddr;
  logic eraseStart, suspendReq, resumeReq, errFlag, seqRstN;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .RECOV_CYC(RECOV_CYC)) uut (
    .clk(clk), .rstN(rstN), .pwrDownN(pwrDownN), .ceN(ceN), .weN(weN),
    .busData(busData), .busAddr(busAddr), .seqBusy(seqBusy),
    .seqSuspended(seqSuspended), .readSel(readSel), .blockAddr(blockAddr),
    .eraseStart(eraseStart), .suspendReq(suspendReq), .resumeReq(resumeReq),
    .errFlag(errFlag), .seqRstN(seqRstN)
  );

  task automatic chkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  // write cycle; returns at the negedge after the commit edge
  task automatic wr(input logic [7:0] d, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    ceN = 1'b0; weN = 1'b0; busData = d; busAddr = a;
    @(negedge clk);
    ceN = 1'b1; weN = 1'b1;
    @(negedge clk);
  endtask

  task automatic pdown();
    @(negedge clk);
    pwrDownN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    pwrDownN = 1'b1;
    repeat (RECOV_CYC + 1) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int exp;
    repeat (3) @(negedge clk);
    chkEq("R8 reset readSel", readSel, 0);
    chkEq("R8 reset errFlag", errFlag, 0);
    chkEq("R8 reset pulses", {eraseStart, suspendReq, resumeReq}, 0);
    rstN = 1'b1;
    // R9: write right after reset release is blocked
    wr(8'h70, '0);
    chkEq("R9 blocked after reset", readSel, 0);
    repeat (RECOV_CYC + 1) @(negedge clk);

    // R2
    wr(8'h70, '0); chkEq("R2 status", readSel, 1);
    wr(8'h90, '0); chkEq("R2 ident", readSel, 2);
    wr(8'hFF, '0); chkEq("R2 array", readSel, 0);

    // R1: chip enable rises first, then data changes before write enable rises
    @(negedge clk); ceN = 1'b0; weN = 1'b0; busData = 8'h70;
    @(negedge clk); ceN = 1'b1;
    @(negedge clk); busData = 8'hFF;
    @(negedge clk); weN = 1'b1;
    @(negedge clk);
    chkEq("R1 ce first", readSel, 1);
    // write enable first
    @(negedge clk); ceN = 1'b0; weN = 1'b0; busData = 8'h90;
    @(negedge clk); weN = 1'b1;
    @(negedge clk); busData = 8'hFF;
    @(negedge clk); ceN = 1'b1;
    @(negedge clk);
    chkEq("R1 we first", readSel, 2);

    // R9: recovery window after power-down
    @(negedge clk); pwrDownN = 1'b0;
    @(negedge clk); pwrDownN = 1'b1;
    wr(8'h90, '0);
    chkEq("R9 blocked in recovery", readSel, 0);
    repeat (RECOV_CYC + 1) @(negedge clk);
    wr(8'h90, '0);
    chkEq("R9 accepted after recovery", readSel, 2);

    // R3: erase to each block
    for (int b = 0; b < (1 << BLK_W); b++) begin
      wr(8'hFF, '0);
      wr(8'h20, '0);
      chkEq("R3 setup status", readSel, 1);
      wr(8'hD0, ADDR_W'((b << (ADDR_W - BLK_W)) | (b * 37 % 64)));
      chkEq("R3 eraseStart", eraseStart, 1);
      chkEq("R3 blockAddr", blockAddr, b);
      chkEq("R3 no error", errFlag, 0);
      @(negedge clk);
      chkEq("R3 pulse one cycle", eraseStart, 0);
    end

    // R4: any other byte after setup
    for (int v = 0; v < 256; v++) begin
      if (v == 8'hD0) continue;
      wr(8'h20, '0);
      wr(8'(v), '1);
      chkEq("R4 errFlag", errFlag, 1);
      chkEq("R4 no start", eraseStart, 0);
      chkEq("R4 status", readSel, 1);
      pdown();
    end
    chkEq("R8 err cleared", errFlag, 0);
    chkEq("R8 array after pd", readSel, 0);

    // R8: pending setup dropped, writes ignored during power-down
    wr(8'h20, '0);
    pdown();
    wr(8'hD0, '0);
    chkEq("R8 setup dropped", eraseStart, 0);
    chkEq("R8 setup dropped err", errFlag, 0);
    @(negedge clk); pwrDownN = 1'b0;
    wr(8'h70, '0);
    chkEq("R8 ignored in pd", readSel, 0);
    chkEq("R8 seqRstN low", seqRstN, 0);
    @(negedge clk); pwrDownN = 1'b1;
    repeat (RECOV_CYC + 1) @(negedge clk);

    // R5
    wr(8'hB0, '0);
    chkEq("R5 idle suspend ignored", suspendReq, 0);
    chkEq("R5 idle readSel", readSel, 0);
    seqBusy = 1'b1;
    wr(8'hB0, '0);
    chkEq("R5 suspendReq", suspendReq, 1);
    chkEq("R5 status", readSel, 1);

    // R10
    wr(8'hFF, '0);
    wr(8'h20, '0);
    chkEq("R10 setup ignored", readSel, 0);
    wr(8'hD0, '0);
    chkEq("R10 confirm ignored start", eraseStart, 0);
    chkEq("R10 confirm ignored err", errFlag, 0);
    chkEq("R10 confirm ignored sel", readSel, 0);

    // R6 / R7: sweep while suspended
    seqSuspended = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wr(8'hFF, '0);
      wr(8'(v), '0);
      exp = (v == 8'h70 || v == 8'hD0) ? 1 : 0;
      chkEq("R6 suspended filter", readSel, exp);
      chkEq("R6 no start/suspend", {eraseStart, suspendReq}, 0);
      chkEq("R7 resumeReq", resumeReq, (v == 8'hD0) ? 1 : 0);
    end
    seqSuspended = 1'b0;
    seqBusy = 1'b0;

    summary();
  end

endmodule